// File: doc/BRIEF.md
# Configuration stream sync and byte-order detector

This block sits at the front of a configuration loader and watches 32-bit words, one per valid beat, while the stream is still unsynchronised. Filler words are swallowed. A bus-width marker word tells the block whether the bytes inside each word arrive reversed. When they do, a byte-swap path is latched on and every later word is corrected before it is examined or passed on.

When the corrected word matches the sync pattern, the block raises a synchronised flag. From the next word on it hands each corrected word to a downstream packet parser over a valid/ready handshake. Before sync, every accepted word also produces a one-cycle class report: filler, width marker one, width marker two, sync, or other.

The word width, byte width and all four match patterns are parameters. A second parameter can remove the swap path. In that variant any reversed marker counts as an order error.

Top module: `cfg_sync_align`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears synced, byte_swapped, order_err and cls_valid. out_valid is low while unsynchronised.
- R2: Before sync, a corrected word equal to 0xFFFFFFFF is classified as filler (cls_code 0) and is not forwarded.
- R3: Before sync, a corrected word equal to 0x000000BB is classified as width marker one (cls_code 1) and leaves byte_swapped unchanged.
- R4: Before sync, while byte_swapped is low, a corrected word equal to 0xBB000000 is classified as cls_code 1 and sets byte_swapped from the next cycle. Once byte_swapped is set, every later word is corrected by exchanging byte 0 (bits 7:0) with byte 3 (bits 31:24), and byte 1 with byte 2.
- R5: A corrected 0xBB000000 seen while byte_swapped is already high sets order_err, which stays high until reset. byte_swapped stays high.
- R6: Before sync, a corrected word equal to 0x11220044 is classified as width marker two (cls_code 2) and is not forwarded.
- R7: Before sync, a corrected word equal to 0xAA995566 is classified as sync (cls_code 3). synced rises in the next cycle, and the sync word itself is not forwarded.
- R8: Any other word before sync is classified as cls_code 4 and changes none of synced, byte_swapped or order_err.
- R9: After sync, out_valid equals in_valid and out_data is the corrected input word, in the same cycle. No class reports are made.
- R10: Before sync, in_ready is high. After sync, in_ready equals out_ready, so the source stalls while downstream is not ready.
- R11: cls_valid is high for exactly one cycle after each accepted pre-sync word (in_valid high, synced low at the clock edge), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | 32 | Raw input word |
| out_valid | output | 1 | Forwarded word present |
| out_ready | input | 1 | Downstream can take the word |
| out_data | output | 32 | Forwarded word, byte order corrected |
| synced | output | 1 | Sync word has been seen |
| byte_swapped | output | 1 | Byte reversal is active |
| order_err | output | 1 | Second reversed marker seen (sticky) |
| cls_valid | output | 1 | Class report strobe for the previous word |
| cls_code | output | 3 | 0 filler, 1 width one, 2 width two, 3 sync, 4 other |

## Verification
A wrongly held swap flag shows up in the same cycle as reversed bytes on out_data. It also shows up one cycle after a marker word, as a wrong cls_code, because classification works on the corrected word. A false or missing sync state shows up at once on in_ready and out_valid. A lost or wrongly set error flag is visible on order_err one cycle after the marker that should or should not have set it. The bench runs a reversed stream with swapped filler, width and sync words, a repeated marker and handshake stalls, and compares every output on every cycle.

// File: rtl/cfg_sync_pkg.sv
package cfg_sync_pkg;
   typedef enum logic [2:0] {
      CLS_PAD   = 3'd0,
      CLS_BW1   = 3'd1,
      CLS_BW2   = 3'd2,
      CLS_SYNC  = 3'd3,
      CLS_OTHER = 3'd4
   } word_cls_e;
endpackage

// File: rtl/cfg_byte_rev.sv
module cfg_byte_rev #(
   parameter int BYTE_W  = 8,
   parameter int N_BYTES = 4,
   localparam int W = BYTE_W * N_BYTES
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < N_BYTES; i++) begin : g_lane
      assign dout[i*BYTE_W +: BYTE_W] = din[(N_BYTES-1-i)*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/cfg_word_class.sv
module cfg_word_class
   import cfg_sync_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int N_BYTES = 4,
   localparam int W = BYTE_W * N_BYTES,
   parameter logic [W-1:0] PAD_PAT  = 32'hFFFF_FFFF,
   parameter logic [W-1:0] BW1_PAT  = 32'h0000_00BB,
   parameter logic [W-1:0] BW2_PAT  = 32'h1122_0044,
   parameter logic [W-1:0] SYNC_PAT = 32'hAA99_5566
) (
   input  logic [W-1:0] word,
   output logic         hit_rev,
   output logic         hit_sync,
   output word_cls_e    cls
);
   logic [W-1:0] bw1_rev_pat;

   cfg_byte_rev #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_mark_rev (
      .din(BW1_PAT), .dout(bw1_rev_pat));

   assign hit_rev  = (word == bw1_rev_pat);
   assign hit_sync = (word == SYNC_PAT);

   always_comb begin
      if (word == PAD_PAT)                cls = CLS_PAD;
      else if (word == BW1_PAT || hit_rev) cls = CLS_BW1;
      else if (word == BW2_PAT)           cls = CLS_BW2;
      else if (hit_sync)                  cls = CLS_SYNC;
      else                                cls = CLS_OTHER;
   end
endmodule

// File: rtl/cfg_sync_state.sv
module cfg_sync_state
   import cfg_sync_pkg::*;
#(
   parameter bit ALLOW_SWAP = 1'b1
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      take,
   input  logic      hit_rev,
   input  logic      hit_sync,
   input  word_cls_e cls,
   output logic      synced,
   output logic      swapped,
   output logic      err,
   output logic      cls_v,
   output word_cls_e cls_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         synced  <= 1'b0;
         swapped <= 1'b0;
         err     <= 1'b0;
         cls_v   <= 1'b0;
         cls_q   <= CLS_PAD;
      end else begin
         cls_v <= take;
         if (take) begin
            cls_q <= cls;
            if (hit_sync) synced <= 1'b1;
            if (hit_rev) begin
               if (ALLOW_SWAP && !swapped) swapped <= 1'b1;
               else                        err     <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfg_sync_align.sv
module cfg_sync_align
   import cfg_sync_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int N_BYTES    = 4,
   parameter bit ALLOW_SWAP = 1'b1,
   localparam int W = BYTE_W * N_BYTES,
   parameter logic [W-1:0] PAD_PAT  = 32'hFFFF_FFFF,
   parameter logic [W-1:0] BW1_PAT  = 32'h0000_00BB,
   parameter logic [W-1:0] BW2_PAT  = 32'h1122_0044,
   parameter logic [W-1:0] SYNC_PAT = 32'hAA99_5566
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         synced,
   output logic         byte_swapped,
   output logic         order_err,
   output logic         cls_valid,
   output logic [2:0]   cls_code
);
   if (BYTE_W < 1 || N_BYTES < 2) begin : g_bad_cfg
      $error("cfg_sync_align: need BYTE_W >= 1 and N_BYTES >= 2");
   end

   logic [W-1:0] fixed_word;
   logic         hit_rev, hit_sync, take;
   word_cls_e    cls_now, cls_reg;

   if (ALLOW_SWAP) begin : g_swap
      logic [W-1:0] rev_word;
      cfg_byte_rev #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_rev (
         .din(in_data), .dout(rev_word));
      assign fixed_word = byte_swapped ? rev_word : in_data;
   end else begin : g_noswap
      assign fixed_word = in_data;
   end

   cfg_word_class #(
      .BYTE_W(BYTE_W), .N_BYTES(N_BYTES),
      .PAD_PAT(PAD_PAT), .BW1_PAT(BW1_PAT),
      .BW2_PAT(BW2_PAT), .SYNC_PAT(SYNC_PAT)
   ) u_class (
      .word(fixed_word), .hit_rev(hit_rev), .hit_sync(hit_sync), .cls(cls_now));

   assign take = in_valid && !synced;

   cfg_sync_state #(.ALLOW_SWAP(ALLOW_SWAP)) u_state (
      .clk(clk), .rst(rst), .take(take),
      .hit_rev(hit_rev), .hit_sync(hit_sync), .cls(cls_now),
      .synced(synced), .swapped(byte_swapped), .err(order_err),
      .cls_v(cls_valid), .cls_q(cls_reg));

   assign cls_code  = cls_reg;
   assign in_ready  = synced ? out_ready : 1'b1;
   assign out_valid = synced && in_valid;
   assign out_data  = fixed_word;
endmodule

// File: rtl/cfg_sync_align_chk.sv
module cfg_sync_align_chk (
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic       synced,
   input logic       byte_swapped,
   input logic       order_err,
   input logic       cls_valid,
   input logic [2:0] cls_code
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!synced && !byte_swapped && !order_err && !cls_valid));

   p_no_fwd_presync_r2: assert property (@(posedge clk) disable iff (rst)
      !synced |-> !out_valid);

   p_swap_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      byte_swapped |=> byte_swapped);

   p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      order_err |=> order_err);

   p_sync_reported_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(synced) |-> (cls_valid && cls_code == 3'd3));

   p_fwd_follows_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (synced && in_valid));

   p_stall_r10: assert property (@(posedge clk) disable iff (rst)
      synced |-> (in_ready == out_ready));

   p_cls_strobe_r11: assert property (@(posedge clk) disable iff (rst)
      cls_valid |-> $past(in_valid && !synced));
endmodule

bind cfg_sync_align cfg_sync_align_chk u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .synced(synced),
   .byte_swapped(byte_swapped), .order_err(order_err),
   .cls_valid(cls_valid), .cls_code(cls_code));

// File: tb/sim_cfg_sync_align.sv
`timescale 1ns/1ps
module sim_cfg_sync_align;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        synced, byte_swapped, order_err, cls_valid;
   logic [2:0]  cls_code;

   int vectors = 0;
   int misses  = 0;

   // reference state
   bit       m_sync = 0, m_sw = 0, m_err = 0, m_cv = 0;
   int       m_code = 0;

   always #5 clk = ~clk;

   cfg_sync_align u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .synced(synced), .byte_swapped(byte_swapped),
      .order_err(order_err), .cls_valid(cls_valid), .cls_code(cls_code));

   function automatic logic [31:0] flip(input logic [31:0] d);
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string code_req(input int c);
      case (c)
         0: return "R2";
         1: return "R3/R4";
         2: return "R6";
         3: return "R7";
         default: return "R8";
      endcase
   endfunction

   // one beat: drive at negedge, compare, then advance model at posedge
   task automatic beat(input bit v, input logic [31:0] d, input bit ordy, input bit r = 0);
      logic [31:0] fix;
      @(negedge clk);
      rst = r; in_valid = v; in_data = d; out_ready = ordy;
      #1;
      fix = m_sw ? flip(d) : d;
      chk("R7",  "synced",       synced,       m_sync);
      chk("R4",  "byte_swapped", byte_swapped, m_sw);
      chk("R5",  "order_err",    order_err,    m_err);
      chk("R11", "cls_valid",    cls_valid,    m_cv);
      if (m_cv) chk(code_req(m_code), "cls_code", cls_code, m_code);
      chk("R10", "in_ready",     in_ready,     m_sync ? ordy : 1'b1);
      chk("R9",  "out_valid",    out_valid,    m_sync && v);
      if (m_sync && v) chk("R9", "out_data", out_data, fix);
      @(posedge clk);
      if (r) begin
         m_sync = 0; m_sw = 0; m_err = 0; m_cv = 0;
      end else begin
         m_cv = v && !m_sync;
         if (m_cv) begin
            if (fix == 32'hFFFF_FFFF)      m_code = 0;
            else if (fix == 32'h0000_00BB) m_code = 1;
            else if (fix == 32'hBB00_0000) begin
               m_code = 1;
               if (m_sw) m_err = 1; else m_sw = 1;
            end
            else if (fix == 32'h1122_0044) m_code = 2;
            else if (fix == 32'hAA99_5566) begin m_code = 3; m_sync = 1; end
            else m_code = 4;
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      beat(0, 32'h0, 0, 1);
      beat(0, 32'h0, 0, 1);
      // R1: reset state at the ports
      @(negedge clk); rst = 0; #1;
      chk("R1", "synced",    synced,    0);
      chk("R1", "swapped",   byte_swapped, 0);
      chk("R1", "order_err", order_err, 0);
      chk("R1", "cls_valid", cls_valid, 0);
      chk("R1", "out_valid", out_valid, 0);
      // normal-order preamble: R2, R3, R6, R8
      beat(1, 32'h1234_5678, 1);
      beat(1, 32'hFFFF_FFFF, 1);
      beat(0, 32'hAA99_5566, 1);   // idle beat, sync pattern ignored
      beat(1, 32'h0000_00BB, 1);
      beat(1, 32'h1122_0044, 1);
      beat(1, 32'h6655_99AA, 1);   // reversed sync before swap: other (R8)
      // reversed marker turns on swapping (R4)
      beat(1, 32'hBB00_0000, 1);
      beat(1, 32'hFFFF_FFFF, 1);
      beat(1, 32'h4400_2211, 1);
      beat(1, 32'hBB00_0000, 0);   // corrected 000000BB: no error
      beat(1, 32'hDEAD_BEEF, 0);
      beat(1, 32'h0000_00BB, 0);   // corrected BB000000: error (R5)
      beat(1, 32'h6655_99AA, 0);   // sync in swapped order (R7)
      // forwarding with stalls (R9, R10)
      for (int i = 0; i < 24; i++)
         beat(i % 3 != 2, 32'h0102_0304 + 32'h1111 * i, i % 4 != 1);
      beat(1, 32'hAA99_5566, 1);   // after sync: just data
      // fresh stream in normal order
      beat(0, 32'h0, 1, 1);
      beat(1, 32'hFFFF_FFFF, 1);
      beat(1, 32'h0000_00BB, 1);
      beat(1, 32'h1122_0044, 1);
      beat(1, 32'hAA99_5566, 1);
      for (int i = 0; i < 16; i++)
         beat(1, 32'hCAFE_0000 | i, i % 2 == 0);
      beat(0, 32'h0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule